// File: doc/BRIEF.md
# Synthesizer Divider Configuration Port

This block holds the configuration word of a clock synthesizer: a 9-bit feedback modulus, a 2-bit output-divider code and a 3-bit test-select code. The word can be written through two paths. The parallel path has a load strobe that is active low. While the strobe is low, the latched modulus and divider code follow the parallel inputs. When the strobe goes high, the last values are held. The serial path uses three wires: a data line, a shift clock and a load strobe. Data enters a 14-bit shift register, and the load strobe moves the register's contents into the configuration latches.

A fast system clock samples every external control line through a two-flop synchronizer, so the whole block is synchronous. The system clock must run at least four times faster than the fastest serial shift clock. A register at the top sees a change on an external line on the third system-clock edge after the change. The parallel strobe has priority: while it is low, serial transfers are blocked and the test-select code is held at zero.

A one-cycle update pulse marks every change of the modulus or divider code, so downstream dividers know when to reload. An observation bit shows the last stage of the shift register when the test-select code is zero.

Top module: `synth_cfg_port`

## Requirements
- R1: After reset the modulus output is 200, the divider code is 00, the test code is 000, the shift register is cleared, the observation bit is 0 and no update pulse is given.
- R2: The shift register takes one data bit on each rising edge of the serial shift clock. A 14-bit word sent most significant bit first lands as test code in bits 13..11, divider code in bits 10..9 and modulus in bits 8..0. Each field arrives most significant bit first.
- R3: While the serial load strobe is high and the parallel strobe is high, the latches follow the shift register. After the serial strobe falls, the latched values hold, and later shifting does not change them.
- R4: While the parallel strobe is low, the modulus and divider code follow the parallel inputs. The values present when the strobe rises are held, and later changes on the parallel inputs have no effect.
- R5: While the parallel strobe is low, a serial load has no effect on any latched value. Once the strobe is high again, a serial load works.
- R6: While the parallel strobe is low, the test code is forced to 000. The parallel path cannot set the test code.
- R7: When the test code is 000, the observation bit equals the last stage (bit 13) of the shift register. For any other test code it is 0.
- R8: The update output is high for exactly one cycle in the cycle in which a new modulus or divider code first appears on the outputs. It is low at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial shift clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| par_load_n_i | input | 1 | Parallel load strobe; transparent while low, holds on its rise |
| par_mod_i | input | 9 | Parallel feedback modulus |
| par_div_i | input | 2 | Parallel output-divider code |
| ser_data_i | input | 1 | Serial data line |
| ser_clk_i | input | 1 | Serial shift clock; shifts on its rising edge |
| ser_load_i | input | 1 | Serial load strobe; transparent while high, holds on its fall |
| mod_o | output | 9 | Latched feedback modulus |
| div_o | output | 2 | Latched output-divider code |
| test_o | output | 3 | Latched test-select code |
| obs_o | output | 1 | Observation bit (shift-register last stage when test code is 000) |
| update_o | output | 1 | One-cycle pulse on any modulus or divider-code change |

## Verification
The parallel path is driven in three conditions: inputs changed while the strobe is high, changed while it is low, and changed after it rises. This separates transparent behaviour from hold behaviour. Serial words are chosen with a different nonzero value in each field, which exposes a wrong field order or bit order. Further words test the following:
- shifting with the load strobe held high, against shifting after it falls;
- a serial load made while the parallel strobe is low, against the same load made after the strobe is released;
- an observation bit read with a zero test code and again with a nonzero one.

Every update pulse is matched against an ordered list of expected modulus and divider values, so both missing pulses and extra pulses show up.

// File: rtl/synth_cfg_pkg.sv
package synth_cfg_pkg;
    localparam int MOD_W  = 9;
    localparam int DIV_W  = 2;
    localparam int TST_W  = 3;
    localparam int WORD_W = TST_W + DIV_W + MOD_W;

    localparam logic [MOD_W-1:0] MOD_RST = MOD_W'(200);
    localparam logic [DIV_W-1:0] DIV_RST = '0;
    localparam logic [TST_W-1:0] TST_RST = '0;

    // Serial word layout: test code on top, modulus at the bottom.
    typedef struct packed {
        logic [TST_W-1:0] tst;
        logic [DIV_W-1:0] div;
        logic [MOD_W-1:0] mod;
    } cfg_word_t;
endpackage

// File: rtl/synth_cfg_sync.sv
// Multi-stage level synchronizer for a bundle of asynchronous control lines.
module synth_cfg_sync #(
    parameter int          WIDTH   = 4,
    parameter int          STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [STAGES-1:0][WIDTH-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d[0] = async_i;
        for (int s = 1; s < STAGES; s++) begin
            pipe_d[s] = pipe_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= {STAGES{RST_VAL}};
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign sync_o = pipe_q[STAGES-1];
endmodule

// File: rtl/synth_cfg_shift.sv
// Serial shift register with its own rising-edge detector on the shift clock.
module synth_cfg_shift #(
    parameter int LEN = 14
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           sclk_lvl_i,
    input  logic           sdata_i,
    output logic [LEN-1:0] sreg_o
);
    typedef struct packed {
        logic [LEN-1:0] sreg;
        logic           sclk_prev;
    } shift_st_t;

    shift_st_t st_d, st_q;

    always_comb begin
        st_d           = st_q;
        st_d.sclk_prev = sclk_lvl_i;
        if (sclk_lvl_i && !st_q.sclk_prev) begin
            st_d.sreg = {st_q.sreg[LEN-2:0], sdata_i};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sreg_o = st_q.sreg;
endmodule

// File: rtl/synth_cfg_latch.sv
// Configuration latches: parallel path with priority, serial path second.
module synth_cfg_latch
    import synth_cfg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pload_n_lvl_i,
    input  logic             sload_lvl_i,
    input  logic [MOD_W-1:0] par_mod_i,
    input  logic [DIV_W-1:0] par_div_i,
    input  cfg_word_t        sword_i,
    output logic [MOD_W-1:0] mod_o,
    output logic [DIV_W-1:0] div_o,
    output logic [TST_W-1:0] tst_o,
    output logic             obs_o,
    output logic             upd_o
);
    typedef struct packed {
        logic [MOD_W-1:0] mod;
        logic [DIV_W-1:0] div;
        logic [TST_W-1:0] tst;
        logic             obs;
        logic             upd;
    } latch_st_t;

    latch_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.upd = 1'b0;
        if (!pload_n_lvl_i) begin
            st_d.mod = par_mod_i;
            st_d.div = par_div_i;
            st_d.tst = '0;
        end else if (sload_lvl_i) begin
            st_d.mod = sword_i.mod;
            st_d.div = sword_i.div;
            st_d.tst = sword_i.tst;
        end
        st_d.upd = (st_d.mod != st_q.mod) || (st_d.div != st_q.div);
        // Observation tap: last stage of the shift register in normal mode.
        st_d.obs = (st_d.tst == '0) ? sword_i.tst[TST_W-1] : 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{mod: MOD_RST, div: DIV_RST, tst: TST_RST, obs: 1'b0, upd: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign mod_o = st_q.mod;
    assign div_o = st_q.div;
    assign tst_o = st_q.tst;
    assign obs_o = st_q.obs;
    assign upd_o = st_q.upd;
endmodule

// File: rtl/synth_cfg_port.sv
module synth_cfg_port
    import synth_cfg_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             par_load_n_i,
    input  logic [MOD_W-1:0] par_mod_i,
    input  logic [DIV_W-1:0] par_div_i,
    input  logic             ser_data_i,
    input  logic             ser_clk_i,
    input  logic             ser_load_i,
    output logic [MOD_W-1:0] mod_o,
    output logic [DIV_W-1:0] div_o,
    output logic [TST_W-1:0] test_o,
    output logic             obs_o,
    output logic             update_o
);
    localparam int IDX_SDATA = 0;
    localparam int IDX_SCLK  = 1;
    localparam int IDX_SLOAD = 2;
    localparam int IDX_PLOAD = 3;
    localparam int NSIG      = 4;
    // Idle levels: parallel strobe high, everything else low.
    localparam logic [NSIG-1:0] SYNC_RST = NSIG'(1) << IDX_PLOAD;

    logic [NSIG-1:0]   async_bus, sync_bus;
    logic [WORD_W-1:0] sreg;
    logic              pload_n_lvl;

    assign async_bus[IDX_SDATA] = ser_data_i;
    assign async_bus[IDX_SCLK]  = ser_clk_i;
    assign async_bus[IDX_SLOAD] = ser_load_i;
    assign async_bus[IDX_PLOAD] = par_load_n_i;
    assign pload_n_lvl          = sync_bus[IDX_PLOAD];

    synth_cfg_sync #(
        .WIDTH   (NSIG),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (SYNC_RST)
    ) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (async_bus),
        .sync_o  (sync_bus)
    );

    synth_cfg_shift #(
        .LEN (WORD_W)
    ) shift_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .sclk_lvl_i (sync_bus[IDX_SCLK]),
        .sdata_i    (sync_bus[IDX_SDATA]),
        .sreg_o     (sreg)
    );

    synth_cfg_latch latch_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .pload_n_lvl_i (pload_n_lvl),
        .sload_lvl_i   (sync_bus[IDX_SLOAD]),
        .par_mod_i     (par_mod_i),
        .par_div_i     (par_div_i),
        .sword_i       (cfg_word_t'(sreg)),
        .mod_o         (mod_o),
        .div_o         (div_o),
        .tst_o         (test_o),
        .obs_o         (obs_o),
        .upd_o         (update_o)
    );
endmodule

// File: rtl/synth_cfg_checker.sv
module synth_cfg_checker
    import synth_cfg_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             pload_n_lvl,
    input logic [MOD_W-1:0] par_mod_i,
    input logic [MOD_W-1:0] mod_o,
    input logic [DIV_W-1:0] div_o,
    input logic [TST_W-1:0] test_o,
    input logic             obs_o,
    input logic             update_o
);
    // R8: a pulse only accompanies a real change
    assert_upd_has_change_R8: assert property (@(posedge clk) disable iff (!rst_n)
        update_o |-> (mod_o != $past(mod_o)) || (div_o != $past(div_o)));

    // R8: every change comes with a pulse
    assert_change_has_upd_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((mod_o != $past(mod_o)) || (div_o != $past(div_o))) |-> update_o);

    // R6: test code forced to zero while the parallel strobe is low
    assert_test_cleared_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !pload_n_lvl |=> (test_o == '0));

    // R4: transparent parallel path
    assert_par_follow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !pload_n_lvl |=> (mod_o == $past(par_mod_i)));

    // R7: observation bit quiet outside normal mode
    assert_obs_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (test_o != '0) |-> !obs_o);
endmodule

bind synth_cfg_port synth_cfg_checker chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .pload_n_lvl (pload_n_lvl),
    .par_mod_i   (par_mod_i),
    .mod_o       (mod_o),
    .div_o       (div_o),
    .test_o      (test_o),
    .obs_o       (obs_o),
    .update_o    (update_o)
);

// File: tb/synth_cfg_port_tb.sv
module synth_cfg_port_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       par_load_n = 1'b1;
    logic [8:0] par_mod = '0;
    logic [1:0] par_div = '0;
    logic       ser_data = 1'b0;
    logic       ser_clk = 1'b0;
    logic       ser_load = 1'b0;
    logic [8:0] mod_o;
    logic [1:0] div_o;
    logic [2:0] test_o;
    logic       obs_o;
    logic       update_o;

    always #4 clk = ~clk;   // 125 MHz

    synth_cfg_port dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .par_load_n_i (par_load_n),
        .par_mod_i    (par_mod),
        .par_div_i    (par_div),
        .ser_data_i   (ser_data),
        .ser_clk_i    (ser_clk),
        .ser_load_i   (ser_load),
        .mod_o        (mod_o),
        .div_o        (div_o),
        .test_o       (test_o),
        .obs_o        (obs_o),
        .update_o     (update_o)
    );

    int n_checks = 0;
    int n_fail   = 0;
    int n_push   = 0;
    int n_pulse  = 0;

    logic [10:0] exp_q[$];    // {div, mod}
    logic [8:0]  cur_mod = 9'd200;
    logic [1:0]  cur_div = 2'd0;
    logic [2:0]  cur_tst = 3'd0;
    logic [13:0] sr_model = '0;

    task automatic chk(string req, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cyc(int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    // Driver side: record what the latches should become.
    task automatic expect_cfg(logic [8:0] m, logic [1:0] d, logic [2:0] t);
        if ({d, m} != {cur_div, cur_mod}) begin
            exp_q.push_back({d, m});
            n_push++;
        end
        cur_mod = m; cur_div = d; cur_tst = t;
    endtask

    task automatic par_set(logic [8:0] m, logic [1:0] d);
        par_mod = m; par_div = d;
        if (!par_load_n) expect_cfg(m, d, 3'd0);
    endtask

    task automatic pload_set(logic v);
        par_load_n = v;
        if (!v) expect_cfg(par_mod, par_div, 3'd0);
    endtask

    task automatic sload_set(logic v);
        ser_load = v;
        if (v && par_load_n) expect_cfg(sr_model[8:0], sr_model[10:9], sr_model[13:11]);
    endtask

    task automatic shift_bit(logic b);
        ser_data = b;
        cyc(3);
        ser_clk = 1'b1;
        sr_model = {sr_model[12:0], b};
        if (ser_load && par_load_n) expect_cfg(sr_model[8:0], sr_model[10:9], sr_model[13:11]);
        cyc(3);
        ser_clk = 1'b0;
        cyc(3);
    endtask

    task automatic shift_word(logic [2:0] t, logic [1:0] d, logic [8:0] m);
        logic [13:0] w;
        w = {t, d, m};
        for (int i = 13; i >= 0; i--) shift_bit(w[i]);
    endtask

    task automatic serial_pulse();
        sload_set(1'b1);
        cyc(6);
        sload_set(1'b0);
        cyc(6);
    endtask

    // Monitor: pop an expected item on every update pulse.
    logic prev_upd = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (update_o) begin
                n_pulse++;
                if (prev_upd) chk("R8 pulse width", 2, 1);
                if (exp_q.size() == 0) begin
                    chk("R8 unexpected pulse", 1, 0);
                end else begin
                    logic [10:0] e;
                    e = exp_q.pop_front();
                    chk("R8 mod at pulse", int'(mod_o), int'(e[8:0]));
                    chk("R8 div at pulse", int'(div_o), int'(e[10:9]));
                end
            end
            prev_upd = update_o;
        end
    end

    task automatic chk_cfg(string req);
        chk({req, " mod"}, int'(mod_o), int'(cur_mod));
        chk({req, " div"}, int'(div_o), int'(cur_div));
        chk({req, " test"}, int'(test_o), int'(cur_tst));
    endtask

    bit done = 1'b0;
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        cyc(5);
        rst_n = 1'b1;
        cyc(5);
        // R1 reset state
        chk("R1 mod", int'(mod_o), 200);
        chk("R1 div", int'(div_o), 0);
        chk("R1 test", int'(test_o), 0);
        chk("R1 obs", int'(obs_o), 0);
        chk("R1 no pulse", n_pulse, 0);

        // R4 parallel path
        par_set(9'd262, 2'd1);         // strobe high: ignored
        cyc(8);
        chk_cfg("R4 ignored while high");
        pload_set(1'b0);
        cyc(8);
        chk_cfg("R4 transparent");
        par_set(9'd300, 2'd2);
        cyc(8);
        chk_cfg("R4 follows");
        pload_set(1'b1);
        cyc(8);
        par_set(9'd5, 2'd3);
        cyc(8);
        chk_cfg("R4 hold after rise");
        chk("R4 hold mod", int'(mod_o), 300);

        // R2/R3 serial load
        shift_word(3'd0, 2'd2, 9'd333);
        cyc(6);
        chk_cfg("R3 no strobe no change");
        serial_pulse();
        chk_cfg("R2 serial word");
        chk("R2 mod value", int'(mod_o), 333);

        // R7 observation
        chk("R7 obs stage13", int'(obs_o), int'(sr_model[13]));
        for (int i = 0; i < 3; i++) shift_bit(1'b0);
        cyc(4);
        chk("R7 obs after 3 shifts", int'(obs_o), 1);
        shift_bit(1'b0);
        cyc(4);
        chk("R7 obs after 4 shifts", int'(obs_o), 0);
        chk_cfg("R3 shifting after fall holds");

        // Test code nonzero
        shift_word(3'd6, 2'd3, 9'd400);
        serial_pulse();
        chk_cfg("R2 test word");
        chk("R7 obs quiet", int'(obs_o), 0);

        // R3 transparent serial latch
        sload_set(1'b1);
        cyc(6);
        shift_bit(1'b1);
        cyc(6);
        chk_cfg("R3 follows while high");
        sload_set(1'b0);
        cyc(6);
        shift_bit(1'b0);
        cyc(6);
        chk_cfg("R3 held after fall");

        // R5/R6 priority
        par_set(9'd210, 2'd0);
        pload_set(1'b0);
        cyc(8);
        chk("R6 test forced", int'(test_o), 0);
        chk_cfg("R6 parallel load");
        shift_word(3'd6, 2'd1, 9'd450);
        ser_load = 1'b1;               // blocked: no expectation
        cyc(6);
        ser_load = 1'b0;
        cyc(8);
        chk_cfg("R5 serial blocked");
        pload_set(1'b1);
        cyc(8);
        chk_cfg("R6 released");
        serial_pulse();
        chk_cfg("R5 serial after release");
        chk("R5 test set", int'(test_o), 6);

        cyc(10);
        chk("R8 queue drained", exp_q.size(), 0);
        chk("R8 pulse count", n_pulse, n_push);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule